// File: doc/BRIEF.md
# Morphable 16-bit Datapath Unit

This block is a pipelined arithmetic unit that changes function from one operand set to the next. Each accepted transfer carries four signed 16-bit operands, a 3-bit function code and a configuration word. The unit returns two 16-bit results. It can work as a multiply-accumulator with a 32-bit accumulator, a radix-2 butterfly, an add/subtract tree, a sum-of-differences or difference-of-sums reducer, a 16-bit LFSR, a loadable counter with a terminal compare, or a max/min comparator. Each 32-bit intermediate result is reduced to 16 bits. The reduction first applies an arithmetic right shift of 0 to 31 places, which selects a bit window. It then either keeps the low 16 bits of the window or clamps the window to the signed 16-bit range.

Both data edges use valid/ready handshakes. Five register stages sit between the operand port and the result port. All stages advance together, so a single global stall provides back-pressure. When `out_valid` is high and `out_ready` is low, the whole pipeline freezes and `in_ready` drops in the same cycle. While `out_valid` is high, `out_y0`, `out_y1` and `out_valid` must hold until the transfer is accepted. `in_valid` and the operand fields must stay stable until `in_ready` is seen. Each operand set carries its function code and configuration word through the pipeline. Operations therefore finish in the function they entered with, even when the code changes on the very next transfer.

Top module: `mdpu`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The accumulator and the counter start at 0, and the LFSR state starts at 16'h0001.
- R2: When `out_ready` is held high, a result appears on the fifth rising edge, counting the edge that accepts its operands. A new operand set is accepted on every cycle.
- R3: While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and `out_valid`, `out_y0` and `out_y1` hold their values. No result is lost or repeated, and results leave in the order their operands arrived.
- R4: Function code 0 (multiply-accumulate) adds the product sum a0*a1+a2*a3 to the 32-bit accumulator, with wrap-around. When configuration bit 0 (clear) is set, the accumulator instead loads the product sum. y0 is the new accumulator value and y1 is the product sum.
- R5: Function code 1 (butterfly) gives y0 = a0+a1 and y1 = a0−a1.
- R6: Function code 2 (add/subtract tree) gives y0 = a0+a1+a2+a3 and y1 = a0−a1+a2−a3.
- R7: Function code 3 (sum of differences) gives y0 = (a0−a1)+(a2−a3) and y1 = |a0−a1|+|a2−a3|.
- R8: Function code 4 (difference of sums) gives y0 = (a0+a1)−(a2+a3) and y1 = (a2+a3)−(a0+a1).
- R9: Function code 5 (LFSR) first sets the next state. With clear set, the next state is a0. Otherwise the state shifts left by one place, and the new bit 0 is the XOR of the state bits selected by the mask 16'hB400. y0 is the next state sign-extended and y1 is 0.
- R10: Function code 6 (counter) first sets the next count. With clear set, the next count is a0. Otherwise it is count+a1, modulo 2^16. y0 is the next count sign-extended. y1 is 1 when the next count equals a2 and 0 otherwise.
- R11: Function code 7 (compare) gives y0 = max(a0,a1) and y1 = min(a2,a3), both signed.
- R12: Configuration bits 6:2 give the shift amount s. With configuration bit 1 clear (truncate mode), each output is bits 15:0 of the 32-bit result arithmetically shifted right by s.
- R13: With configuration bit 1 set (saturate mode), each shifted result is clamped to the range −32768 to 32767.
- R14: The function code and configuration word act per operand set. Transfers of different functions that are accepted back to back each produce the result of their own function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set accepted on this edge when in_valid is high |
| in_a0 | input | 16 | Operand a0, signed |
| in_a1 | input | 16 | Operand a1, signed |
| in_a2 | input | 16 | Operand a2, signed |
| in_a3 | input | 16 | Operand a3, signed |
| in_mode | input | 3 | Function code, 0 to 7 |
| in_cfg | input | 7 | bit0 clear/load, bit1 saturate, bits 6:2 shift amount |
| out_valid | output | 1 | Result pair available |
| out_ready | input | 1 | Sink takes the result pair on this edge |
| out_y0 | output | 16 | First result |
| out_y1 | output | 16 | Second result |

## Verification
The bench goes after the places where a wrong design would return plausible numbers. An accumulator that is not cleared by the clear bit carries old sums into the next dot product. The product sum of two −32768 squares must wrap to −2^31, so a design that widens or clamps the accumulator gives a different value. A shift window taken with a logical shift or a wrong clamp bound returns the wrong sign at the saturation edges. The bench switches function and configuration on every cycle and throttles `out_ready` in a pattern. A design that decoded the mode at a late stage from the live input, or that advanced LFSR or counter state during a stall, would then produce results in a different order or with different values from the scoreboard.

// File: rtl/mdpu_pkg.sv
package mdpu_pkg;

  // Function codes carried with each operand set
  typedef enum logic [2:0] {
    F_MAC  = 3'd0,
    F_BFLY = 3'd1,
    F_TREE = 3'd2,
    F_SOD  = 3'd3,
    F_DOS  = 3'd4,
    F_LFSR = 3'd5,
    F_CNT  = 3'd6,
    F_CMP  = 3'd7
  } func_e;

endpackage

// File: rtl/mdpu_alu.sv
module mdpu_alu
  import mdpu_pkg::*;
#(
  parameter int          DW   = 16,
  parameter int          AW   = 32,
  parameter logic [DW-1:0] TAPS = 16'hB400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  func_e                func,
  input  logic                 load,
  input  logic [DW-1:0]        a0,
  input  logic [DW-1:0]        a1,
  input  logic [DW-1:0]        a2,
  input  logic [DW-1:0]        a3,
  output logic signed [AW-1:0] r0,
  output logic signed [AW-1:0] r1
);

  localparam int XW = AW - DW;

  logic signed [AW-1:0] x0, x1, x2, x3;
  logic signed [AW-1:0] d0, d1, e0, e1;
  logic [DW-1:0] lfsr_q, lfsr_nx;
  logic [DW-1:0] cnt_q, cnt_nx;

  assign x0 = {{XW{a0[DW-1]}}, a0};
  assign x1 = {{XW{a1[DW-1]}}, a1};
  assign x2 = {{XW{a2[DW-1]}}, a2};
  assign x3 = {{XW{a3[DW-1]}}, a3};

  assign d0 = x0 - x1;
  assign d1 = x2 - x3;
  assign e0 = x0 + x1;
  assign e1 = x2 + x3;

  assign lfsr_nx = load ? a0 : {lfsr_q[DW-2:0], ^(lfsr_q & TAPS)};
  assign cnt_nx  = load ? a0 : cnt_q + a1;

  always_comb begin
    r0 = '0;
    r1 = '0;
    unique case (func)
      F_MAC: begin
        r0 = x0 * x1 + x2 * x3;
        r1 = '0;
      end
      F_BFLY: begin
        r0 = e0;
        r1 = d0;
      end
      F_TREE: begin
        r0 = e0 + e1;
        r1 = d0 + d1;
      end
      F_SOD: begin
        r0 = d0 + d1;
        r1 = (d0[AW-1] ? -d0 : d0) + (d1[AW-1] ? -d1 : d1);
      end
      F_DOS: begin
        r0 = e0 - e1;
        r1 = e1 - e0;
      end
      F_LFSR: begin
        r0 = {{XW{lfsr_nx[DW-1]}}, lfsr_nx};
        r1 = '0;
      end
      F_CNT: begin
        r0 = {{XW{cnt_nx[DW-1]}}, cnt_nx};
        r1 = {{(AW-1){1'b0}}, (cnt_nx == a2)};
      end
      F_CMP: begin
        r0 = (x0 > x1) ? x0 : x1;
        r1 = (x2 < x3) ? x2 : x3;
      end
      default: begin
        r0 = '0;
        r1 = '0;
      end
    endcase
  end

  // Sequence state advances only when its own operation leaves stage 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= {{(DW-1){1'b0}}, 1'b1};
      cnt_q  <= '0;
    end else if (step) begin
      if (func == F_LFSR) lfsr_q <= lfsr_nx;
      if (func == F_CNT)  cnt_q  <= cnt_nx;
    end
  end

endmodule

// File: rtl/mdpu_cond.sv
module mdpu_cond #(
  parameter int DW  = 16,
  parameter int AW  = 32,
  parameter int SHW = 5
) (
  input  logic signed [AW-1:0] raw,
  input  logic                 sat,
  input  logic [SHW-1:0]       sh,
  output logic [DW-1:0]        y
);

  localparam logic signed [AW-1:0] HI = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] LO = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [AW-1:0] win;

  assign win = raw >>> sh;

  always_comb begin
    if (sat && (win > HI))      y = HI[DW-1:0];
    else if (sat && (win < LO)) y = LO[DW-1:0];
    else                        y = win[DW-1:0];
  end

endmodule

// File: rtl/mdpu.sv
module mdpu
  import mdpu_pkg::*;
#(
  parameter int            DW   = 16,
  parameter int            AW   = 32,
  parameter int            SHW  = 5,
  parameter logic [DW-1:0] TAPS = 16'hB400,
  localparam int           CW   = SHW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_a0,
  input  logic [DW-1:0] in_a1,
  input  logic [DW-1:0] in_a2,
  input  logic [DW-1:0] in_a3,
  input  logic [2:0]    in_mode,
  input  logic [CW-1:0] in_cfg,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_y0,
  output logic [DW-1:0] out_y1
);

  localparam int LANES = 2;

  logic adv, take;

  // stage 1: captured operands
  logic           s1_v, s1_ld, s1_sat;
  logic [SHW-1:0] s1_sh;
  func_e          s1_f;
  logic [DW-1:0]  s1_a0, s1_a1, s1_a2, s1_a3;

  // stage 2: raw function results
  logic                 s2_v, s2_ld, s2_sat;
  logic [SHW-1:0]       s2_sh;
  func_e                s2_f;
  logic signed [AW-1:0] s2_r0, s2_r1;
  logic signed [AW-1:0] alu_r0, alu_r1;

  // stage 3: after accumulation
  logic                 s3_v, s3_sat;
  logic [SHW-1:0]       s3_sh;
  logic signed [AW-1:0] s3_r [LANES];
  logic signed [AW-1:0] acc_q, acc_nx;

  // stage 4: conditioned results, stage 5: output
  logic          s4_v, s5_v;
  logic [DW-1:0] s4_yn [LANES];
  logic [DW-1:0] s4_y  [LANES];
  logic [DW-1:0] s5_y  [LANES];

  assign adv      = !(s5_v && !out_ready);
  assign in_ready = adv;
  assign take     = in_valid && adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_ld  <= 1'b0;
      s1_sat <= 1'b0;
      s1_sh  <= '0;
      s1_f   <= F_MAC;
      s1_a0  <= '0;
      s1_a1  <= '0;
      s1_a2  <= '0;
      s1_a3  <= '0;
    end else if (adv) begin
      s1_v <= take;
      if (take) begin
        s1_ld  <= in_cfg[0];
        s1_sat <= in_cfg[1];
        s1_sh  <= in_cfg[CW-1:2];
        s1_f   <= func_e'(in_mode);
        s1_a0  <= in_a0;
        s1_a1  <= in_a1;
        s1_a2  <= in_a2;
        s1_a3  <= in_a3;
      end
    end
  end

  mdpu_alu #(.DW(DW), .AW(AW), .TAPS(TAPS)) u_alu (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (adv && s1_v),
    .func  (s1_f),
    .load  (s1_ld),
    .a0    (s1_a0),
    .a1    (s1_a1),
    .a2    (s1_a2),
    .a3    (s1_a3),
    .r0    (alu_r0),
    .r1    (alu_r1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v   <= 1'b0;
      s2_ld  <= 1'b0;
      s2_sat <= 1'b0;
      s2_sh  <= '0;
      s2_f   <= F_MAC;
      s2_r0  <= '0;
      s2_r1  <= '0;
    end else if (adv) begin
      s2_v   <= s1_v;
      s2_ld  <= s1_ld;
      s2_sat <= s1_sat;
      s2_sh  <= s1_sh;
      s2_f   <= s1_f;
      s2_r0  <= alu_r0;
      s2_r1  <= alu_r1;
    end
  end

  assign acc_nx = (s2_ld ? '0 : acc_q) + s2_r0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      s3_v   <= 1'b0;
      s3_sat <= 1'b0;
      s3_sh  <= '0;
      s3_r[0] <= '0;
      s3_r[1] <= '0;
    end else if (adv) begin
      s3_v   <= s2_v;
      s3_sat <= s2_sat;
      s3_sh  <= s2_sh;
      if (s2_f == F_MAC) begin
        s3_r[0] <= acc_nx;
        s3_r[1] <= s2_r0;
        if (s2_v) acc_q <= acc_nx;
      end else begin
        s3_r[0] <= s2_r0;
        s3_r[1] <= s2_r1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mdpu_cond #(.DW(DW), .AW(AW), .SHW(SHW)) u_cond (
      .raw (s3_r[g]),
      .sat (s3_sat),
      .sh  (s3_sh),
      .y   (s4_yn[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s4_y[g] <= '0;
        s5_y[g] <= '0;
      end else if (adv) begin
        s4_y[g] <= s4_yn[g];
        s5_y[g] <= s4_y[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s4_v <= 1'b0;
      s5_v <= 1'b0;
    end else if (adv) begin
      s4_v <= s3_v;
      s5_v <= s4_v;
    end
  end

  assign out_valid = s5_v;
  assign out_y0    = s5_y[0];
  assign out_y1    = s5_y[1];

endmodule

// File: rtl/mdpu_chk.sv
module mdpu_chk #(
  parameter int DW  = 16,
  parameter int AW  = 32,
  parameter int SHW = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 in_ready,
  input logic [DW-1:0]        out_y0,
  input logic [DW-1:0]        out_y1,
  input logic                 s3_v,
  input logic                 s3_sat,
  input logic [SHW-1:0]       s3_sh,
  input logic signed [AW-1:0] raw0,
  input logic [DW-1:0]        s4_y0
);

  localparam logic signed [AW-1:0] TOP = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] BOT = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic                 moving;
  logic signed [AW-1:0] shv;

  assign moving = !(out_valid && !out_ready);
  assign shv    = raw0 >>> s3_sh;

  // R3
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_y0) && $stable(out_y1));

  // R3
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R3
  drain_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |-> in_ready);

  // R13
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    moving && s3_v && s3_sat && (shv > TOP) |=> s4_y0 == TOP[DW-1:0]);

  // R13
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    moving && s3_v && s3_sat && (shv < BOT) |=> s4_y0 == BOT[DW-1:0]);

  // R12
  trunc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    moving && s3_v && !s3_sat && (s3_sh == '0) |=> s4_y0 == $past(raw0[DW-1:0]));

endmodule

bind mdpu mdpu_chk #(.DW(DW), .AW(AW), .SHW(SHW)) u_mdpu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .in_ready  (in_ready),
  .out_y0    (out_y0),
  .out_y1    (out_y1),
  .s3_v      (s3_v),
  .s3_sat    (s3_sat),
  .s3_sh     (s3_sh),
  .raw0      (s3_r[0]),
  .s4_y0     (s4_y[0])
);

// File: tb/test_mdpu.sv
module test_mdpu;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] y0;
    logic [15:0] y1;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_a0 = '0, in_a1 = '0, in_a2 = '0, in_a3 = '0;
  logic [2:0]  in_mode = '0;
  logic [6:0]  in_cfg = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_y0, out_y1;

  int   errors = 0;
  int   checks = 0;
  exp_t q[$];
  bit   bp_on = 1'b0;
  int   cyc = 0;

  int          m_acc = 0;
  logic [15:0] m_lfsr = 16'h0001;
  logic [15:0] m_cnt = 16'h0000;

  mdpu i_mdpu (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a0(in_a0), .in_a1(in_a1), .in_a2(in_a2), .in_a3(in_a3),
    .in_mode(in_mode), .in_cfg(in_cfg),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_y0(out_y0), .out_y1(out_y1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] mk(input bit ld, input bit sat, input int sh);
    logic [4:0] s = sh[4:0];
    return {s, sat, ld};
  endfunction

  function automatic logic [15:0] reduce(input int raw, input bit sat, input int sh);
    int w = raw >>> sh;
    if (sat && w > 32767)  return 16'h7FFF;
    if (sat && w < -32768) return 16'h8000;
    return w[15:0];
  endfunction

  // Reference model from the requirements, updated in acceptance order
  task automatic model(input logic [2:0] m, input logic [6:0] cfg,
                       input logic [15:0] u0, u1, u2, u3, input string req);
    int a0 = int'($signed(u0));
    int a1 = int'($signed(u1));
    int a2 = int'($signed(u2));
    int a3 = int'($signed(u3));
    int r0 = 0, r1 = 0, p, d0, d1;
    bit ld = cfg[0];
    exp_t e;
    case (m)
      3'd0: begin p = a0*a1 + a2*a3; m_acc = (ld ? 0 : m_acc) + p; r0 = m_acc; r1 = p; end
      3'd1: begin r0 = a0 + a1; r1 = a0 - a1; end
      3'd2: begin r0 = a0 + a1 + a2 + a3; r1 = a0 - a1 + a2 - a3; end
      3'd3: begin
        d0 = a0 - a1; d1 = a2 - a3;
        r0 = d0 + d1;
        r1 = (d0 < 0 ? -d0 : d0) + (d1 < 0 ? -d1 : d1);
      end
      3'd4: begin r0 = (a0 + a1) - (a2 + a3); r1 = (a2 + a3) - (a0 + a1); end
      3'd5: begin
        m_lfsr = ld ? u0 : {m_lfsr[14:0], ^(m_lfsr & 16'hB400)};
        r0 = int'($signed(m_lfsr)); r1 = 0;
      end
      3'd6: begin
        m_cnt = ld ? u0 : m_cnt + u1;
        r0 = int'($signed(m_cnt)); r1 = (m_cnt == u2) ? 1 : 0;
      end
      default: begin r0 = (a0 > a1) ? a0 : a1; r1 = (a2 < a3) ? a2 : a3; end
    endcase
    e.y0 = reduce(r0, cfg[1], int'(cfg[6:2]));
    e.y1 = reduce(r1, cfg[1], int'(cfg[6:2]));
    e.req = req;
    q.push_back(e);
  endtask

  // Driver: called at posedge+2, returns at posedge+2 after acceptance
  task automatic send(input logic [2:0] m, input logic [6:0] cfg,
                      input logic [15:0] u0, u1, u2, u3, input string req);
    bit ok;
    model(m, cfg, u0, u1, u2, u3, req);
    in_valid = 1'b1; in_mode = m; in_cfg = cfg;
    in_a0 = u0; in_a1 = u1; in_a2 = u2; in_a3 = u3;
    do begin
      @(negedge clk);
      ok = in_ready;
      @(posedge clk);
      #2;
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #2;
  endtask

  // Sink pacing
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      out_ready = bp_on ? ((cyc % 3) != 0 && (cyc % 7) != 0) : 1'b1;
    end
  end

  // Monitor / scoreboard
  initial begin
    bit          held = 1'b0;
    logic [15:0] h0 = '0, h1 = '0;
    exp_t        e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (held) begin
          // R3: held result must not move
          check(out_valid && out_y0 == h0 && out_y1 == h1, "R3", "held y0",
                int'(out_y0), int'(h0));
        end
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            check(1'b0, "R3", "unexpected result", int'(out_y0), 0);
          end else begin
            e = q.pop_front();
            check(out_y0 == e.y0, e.req, "y0", int'(out_y0), int'(e.y0));
            check(out_y1 == e.y1, e.req, "y1", int'(out_y1), int'(e.y1));
          end
        end
        held = out_valid && !out_ready;
        h0 = out_y0;
        h1 = out_y1;
      end
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int    n;
    time   t0;
    logic [15:0] v0, v1, v2, v3;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(posedge clk); #2;

    // R1: initial accumulator, LFSR and counter state seen through first ops
    send(3'd0, mk(0, 0, 0), 16'd3, 16'd4, 16'd5, 16'd6, "R1");
    send(3'd5, mk(0, 0, 0), 16'd0, 16'd0, 16'd0, 16'd0, "R1");
    send(3'd6, mk(0, 0, 0), 16'd0, 16'd1, 16'd1, 16'd0, "R1");
    drain();

    // R2: latency of a lone operation
    send(3'd1, mk(0, 0, 0), 16'd100, 16'd7, 16'd0, 16'd0, "R2");
    n = 0;
    do begin @(negedge clk); n++; end while (!out_valid && n < 20);
    check(n == 5, "R2", "latency edges", n, 5);
    drain();

    // R2: one acceptance per cycle
    t0 = $time;
    for (int i = 0; i < 8; i++)
      send(3'(i), mk(0, 0, 0), 16'(i * 3), 16'(i + 1), 16'(5 - i), 16'(i * i), "R2");
    check(($time - t0) == 8 * CLK_PERIOD, "R2", "burst time",
          int'($time - t0), 8 * CLK_PERIOD);
    drain();

    // R4: clear, accumulate, negative terms, wrap of the 32-bit accumulator
    send(3'd0, mk(1, 0, 0), 16'd10, 16'd20, 16'd1, 16'd2, "R4");
    send(3'd0, mk(0, 0, 0), 16'hFFFF, 16'd50, 16'd3, 16'd3, "R4");
    send(3'd0, mk(0, 0, 8), 16'd1000, 16'd1000, 16'hFC18, 16'd7, "R4");
    send(3'd0, mk(1, 1, 0), 16'h8000, 16'h8000, 16'h8000, 16'h8000, "R4");
    send(3'd0, mk(1, 0, 16), 16'h8000, 16'h8000, 16'h8000, 16'h8000, "R4");
    send(3'd0, mk(0, 1, 4), 16'h7FFF, 16'h7FFF, 16'd0, 16'd0, "R4");

    // R5: butterfly including carries out of 16 bits
    send(3'd1, mk(0, 0, 0), 16'd1234, 16'd4321, 16'd0, 16'd0, "R5");
    send(3'd1, mk(0, 1, 0), 16'h7FFF, 16'h7FFF, 16'd0, 16'd0, "R5");
    send(3'd1, mk(0, 0, 1), 16'h7FFF, 16'h8000, 16'd0, 16'd0, "R5");

    // R6, R7, R8, R11
    send(3'd2, mk(0, 0, 0), 16'd1, 16'd2, 16'd3, 16'd4, "R6");
    send(3'd2, mk(0, 1, 1), 16'h7000, 16'h7000, 16'h7000, 16'h9000, "R6");
    send(3'd3, mk(0, 0, 0), 16'd5, 16'd9, 16'hFFF6, 16'd20, "R7");
    send(3'd3, mk(0, 1, 0), 16'h8000, 16'h7FFF, 16'h7FFF, 16'h8000, "R7");
    send(3'd4, mk(0, 0, 0), 16'd100, 16'd200, 16'd7, 16'hFFFE, "R8");
    send(3'd4, mk(0, 1, 0), 16'h8000, 16'h8000, 16'h7FFF, 16'h7FFF, "R8");
    send(3'd7, mk(0, 0, 0), 16'hFFFB, 16'd3, 16'd9, 16'hFF00, "R11");
    send(3'd7, mk(0, 0, 0), 16'h8000, 16'h7FFF, 16'h7FFF, 16'h8000, "R11");
    drain();

    // R9: seeded LFSR run
    send(3'd5, mk(1, 0, 0), 16'hACE1, 16'd0, 16'd0, 16'd0, "R9");
    for (int i = 0; i < 20; i++)
      send(3'd5, mk(0, 0, 0), 16'd0, 16'd0, 16'd0, 16'd0, "R9");

    // R10: loaded counter, terminal compare, wrap
    send(3'd6, mk(1, 0, 0), 16'd10, 16'd0, 16'd30, 16'd0, "R10");
    for (int i = 0; i < 5; i++)
      send(3'd6, mk(0, 0, 0), 16'd0, 16'd5, 16'd30, 16'd0, "R10");
    send(3'd6, mk(1, 0, 0), 16'hFFFF, 16'd0, 16'd0, 16'd0, "R10");
    send(3'd6, mk(0, 0, 0), 16'd0, 16'd1, 16'd0, 16'd0, "R10");
    drain();

    // R12, R13: shift windows in both reduction modes
    for (int s = 0; s < 20; s += 4) begin
      send(3'd0, mk(1, 0, s), 16'h7FFF, 16'h7FFF, 16'h1234, 16'h0FED, "R12");
      send(3'd0, mk(1, 1, s), 16'h7FFF, 16'h7FFF, 16'h1234, 16'h0FED, "R13");
      send(3'd0, mk(1, 1, s), 16'h8000, 16'h7FFF, 16'h8000, 16'h1000, "R13");
    end
    send(3'd1, mk(0, 0, 31), 16'h8000, 16'h0001, 16'd0, 16'd0, "R12");
    drain();

    // R14: function and configuration change on every transfer
    send(3'd0, mk(1, 0, 0), 16'd2, 16'd3, 16'd4, 16'd5, "R14");
    send(3'd1, mk(0, 1, 0), 16'h7FFF, 16'd9, 16'd0, 16'd0, "R14");
    send(3'd0, mk(0, 0, 1), 16'd6, 16'd7, 16'd0, 16'd0, "R14");
    send(3'd7, mk(0, 0, 0), 16'd4, 16'd8, 16'd1, 16'd2, "R14");
    send(3'd5, mk(0, 0, 0), 16'd0, 16'd0, 16'd0, 16'd0, "R14");
    send(3'd6, mk(0, 0, 0), 16'd0, 16'd2, 16'd0, 16'd0, "R14");
    send(3'd0, mk(0, 1, 0), 16'd1, 16'd1, 16'd1, 16'd1, "R14");
    drain();

    // R3: throttled sink across mixed traffic
    bp_on = 1'b1;
    for (int i = 0; i < 60; i++) begin
      v0 = 16'($urandom);
      v1 = 16'($urandom);
      v2 = 16'($urandom);
      v3 = 16'($urandom);
      send(3'(i % 8), mk(i % 5 == 0, i % 2 == 1, (i * 3) % 18), v0, v1, v2, v3, "R3");
    end
    while (q.size() != 0) @(posedge clk);
    bp_on = 1'b0;
    drain();

    check(q.size() == 0, "R3", "results outstanding", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule